// File: doc/BRIEF.md
# MII Management Auto-Poll Engine

This block watches one register of an external Ethernet PHY without help from software. It reads the register again and again over the two-wire management interface (MDC clock, MDIO data) and keeps the last value it read. After each read it compares the new value with the stored one. If they differ, it raises a sticky interrupt flag. Software only has to handle that flag, so it never has to poll the PHY itself.

A 16-bit control word chooses what is watched: the PHY address, the register number and whether the preamble is sent. A default-PHY override replaces the address and preamble choice with values from the port that manages the default PHY. Those values are the default PHY address, plus a flag saying whether that PHY accepts frames without a preamble.

The block contains four parts:
- the MDC divider,
- the serializer for read frames,
- the timer for the idle gap between reads,
- the change detector.

Polling needs two enables to be high at once: the enable bit in the control word, and a chip-level auto-poll enable input.

Top module: `mgmt_autopoll`

## Requirements
- R1: After reset the control word reads back as 0. A write stores bits 15, 12-8, 6, 5 and 4-0. Bits 14, 13 and 7 always read back as 0.
- R2: MDC toggles and MDIO is driven only while control bit 15 and `globalEn` are both 1. Otherwise no frame is started.
- R3: A read frame has the following parts, each bit sent MSB first: 32 ones (the preamble, when it is not dropped), then 0, 1, 1, 0, then the 5-bit PHY address, then the 5-bit register number. MDIO is then released for two MDC periods. After that, 16 data bits are captured MSB first. The captured value appears on `polledValue` when the frame ends.
- R4: When bit 5 is 0, the PHY address comes from bits 4-0 and the register number from bits 12-8. Bit 6 = 1 drops the preamble.
- R5: When bit 5 is 1, bits 4-0 and bit 6 are ignored and the address comes from `dfltPhyAddr`. In this mode the preamble is dropped exactly when `dfltNoPre` is 1.
- R6: `changeIrq` is set at the end of a frame whose value differs from the previous read of the same target. A frame that returns an unchanged value leaves it untouched.
- R7: The first read after polling is enabled, and the first read after the effective PHY address or register number changes, only loads the stored value. It never sets `changeIrq`.
- R8: `changeIrq` stays at 1 until a one-cycle pulse on `irqClear`. If a change is detected in the same cycle as the clear, the flag stays at 1.
- R9: MDC has a period of `MDC_DIV` clocks, with the low half first. MDIO output changes only while MDC is low. Within a frame, successive MDC rising edges are exactly `MDC_DIV` clocks apart.
- R10: The last MDC rising edge of one frame and the first rising edge of the next are exactly `MDC_DIV + intervalCycles + 1` clocks apart.
- R11: When polling is disabled in the middle of a frame, the frame is abandoned. In the next cycle MDC is 0 and `mdioOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| globalEn | input | 1 | Chip-level auto-poll enable |
| cfgWrite | input | 1 | Write strobe for the control word |
| cfgData | input | 16 | Control word write data |
| ctrlQ | output | 16 | Control word read-back |
| dfltPhyAddr | input | 5 | Default PHY address, used when bit 5 is set |
| dfltNoPre | input | 1 | Default PHY accepts frames without a preamble |
| intervalCycles | input | INTERVAL_W | Idle clocks between frames |
| irqClear | input | 1 | Write-1-to-clear pulse for the change flag |
| changeIrq | output | 1 | Sticky change flag |
| polledValue | output | 16 | Last value read from the PHY |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data output |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data input |

## Verification
The hardest case to reach from the ports is an `irqClear` pulse that lands exactly in the cycle in which a frame completes and its comparison runs. Any other alignment shows only ordinary clearing or setting. The bench's PHY model raises an event at the last data rising edge of MDC. A forked task then counts the half-period of clocks that remain and pulses the clear into that exact cycle. This is done once with a changed value and once with an unchanged value. A second case that is hard to reach is a disable that arrives in the middle of a frame. The bench reaches it by waiting until its decoder is inside the header bits.

// File: rtl/mgmt_autopoll_pkg.sv
package mgmt_autopoll_pkg;

  // Bit positions inside one read frame (index of the MDC period).
  localparam logic [5:0] IDX_HDR     = 6'd32;  // first bit after the preamble
  localparam logic [5:0] IDX_HDR_END = 6'd45;  // last header bit
  localparam logic [5:0] IDX_DATA    = 6'd48;  // first data bit after turnaround
  localparam logic [5:0] IDX_LAST    = 6'd63;  // last data bit

  // Control word field positions.
  localparam int EN_POS    = 15;
  localparam int REG_HI    = 12;
  localparam int REG_LO    = 8;
  localparam int NOPRE_POS = 6;
  localparam int DFLT_POS  = 5;
  localparam int PHY_HI    = 4;

  // Start bits followed by the read opcode.
  localparam logic [3:0] READ_LEAD = 4'b0110;

  typedef struct packed {
    logic       start;   // frame begins next cycle, latch target
    logic       drive;   // launch the bit for bitIdx
    logic       sample;  // capture mdioIn (data region)
    logic       done;    // frame finished, compare now
    logic       abort;   // frame abandoned
    logic       active;  // a frame is in progress
    logic [5:0] bitIdx;  // current bit period
  } seq_strobe_t;

endpackage

// File: rtl/mgmt_autopoll_ctrl.sv
module mgmt_autopoll_ctrl
  import mgmt_autopoll_pkg::*;
#(
  parameter int MDC_DIV    = 8,
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pollOn,
  input  logic                  skipPre,
  input  logic [INTERVAL_W-1:0] intervalCycles,
  output logic                  mdc,
  output seq_strobe_t           strb
);

  localparam int HALF  = MDC_DIV / 2;
  localparam int DIV_W = $clog2(MDC_DIV);

  typedef enum logic {ST_IDLE, ST_FRAME} seq_state_e;

  seq_state_e            state;
  logic [INTERVAL_W-1:0] idleCnt;
  logic [DIV_W-1:0]      divCnt;
  logic [5:0]            bitIdx;
  logic                  lastPhase;
  logic                  inFrame;

  assign inFrame   = (state == ST_FRAME);
  assign lastPhase = (divCnt == DIV_W'(MDC_DIV - 1));

  always_comb begin
    strb        = '0;
    strb.active = inFrame;
    strb.bitIdx = bitIdx;
    strb.start  = !inFrame && pollOn && (idleCnt >= intervalCycles);
    strb.drive  = inFrame && pollOn && (divCnt == '0);
    strb.sample = inFrame && pollOn && (divCnt == DIV_W'(HALF - 1)) && (bitIdx >= IDX_DATA);
    strb.done   = inFrame && pollOn && lastPhase && (bitIdx == IDX_LAST);
    strb.abort  = inFrame && !pollOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
      divCnt  <= '0;
      bitIdx  <= '0;
      mdc     <= 1'b0;
    end else if (!pollOn) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
      divCnt  <= '0;
      bitIdx  <= '0;
      mdc     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          mdc <= 1'b0;
          if (strb.start) begin
            state   <= ST_FRAME;
            idleCnt <= '0;
            divCnt  <= '0;
            bitIdx  <= skipPre ? IDX_HDR : 6'd0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_FRAME: begin
          // MDC high during the second half of each bit period.
          mdc <= !lastPhase && (divCnt >= DIV_W'(HALF - 1));
          if (lastPhase) begin
            divCnt <= '0;
            if (bitIdx == IDX_LAST) begin
              state   <= ST_IDLE;
              idleCnt <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mgmt_autopoll_dp.sv
module mgmt_autopoll_dp
  import mgmt_autopoll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        globalEn,
  input  logic        cfgWrite,
  input  logic [15:0] cfgData,
  input  logic [4:0]  dfltPhyAddr,
  input  logic        dfltNoPre,
  input  logic        irqClear,
  input  logic        mdioIn,
  input  seq_strobe_t strb,
  output logic [15:0] ctrlQ,
  output logic        pollOn,
  output logic        skipPre,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic        changeIrq,
  output logic [15:0] polledValue
);

  logic        cfgEn;
  logic [4:0]  cfgReg;
  logic        cfgNoPre;
  logic        cfgDflt;
  logic [4:0]  cfgPhy;

  logic [4:0]  effPhy;
  logic [13:0] frameHdr;
  logic [9:0]  frameTarget;
  logic [9:0]  baseTarget;
  logic        baseValid;
  logic [15:0] shiftIn;
  logic [3:0]  hdrSel;
  logic        changeSet;

  // Control word storage; reserved positions are not kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgReg   <= '0;
      cfgNoPre <= 1'b0;
      cfgDflt  <= 1'b0;
      cfgPhy   <= '0;
    end else if (cfgWrite) begin
      cfgEn    <= cfgData[EN_POS];
      cfgReg   <= cfgData[REG_HI:REG_LO];
      cfgNoPre <= cfgData[NOPRE_POS];
      cfgDflt  <= cfgData[DFLT_POS];
      cfgPhy   <= cfgData[PHY_HI:0];
    end
  end

  assign ctrlQ   = {cfgEn, 2'b00, cfgReg, 1'b0, cfgNoPre, cfgDflt, cfgPhy};
  assign pollOn  = cfgEn && globalEn;
  assign effPhy  = cfgDflt ? dfltPhyAddr : cfgPhy;
  assign skipPre = cfgDflt ? dfltNoPre : cfgNoPre;
  assign hdrSel  = 4'(IDX_HDR_END - strb.bitIdx);

  // Target latched at frame start so mid-frame writes do not disturb it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameHdr    <= '0;
      frameTarget <= '0;
    end else if (strb.start) begin
      frameHdr    <= {READ_LEAD, effPhy, cfgReg};
      frameTarget <= {effPhy, cfgReg};
    end
  end

  // Serializer: bit launched at the start of the MDC low half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else if (!strb.active || strb.abort) begin
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else if (strb.drive) begin
      if (strb.bitIdx < IDX_HDR) begin
        mdioOut <= 1'b1;
        mdioOe  <= 1'b1;
      end else if (strb.bitIdx <= IDX_HDR_END) begin
        mdioOut <= frameHdr[hdrSel];
        mdioOe  <= 1'b1;
      end else begin
        mdioOut <= 1'b0;
        mdioOe  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftIn <= '0;
    else if (strb.sample) shiftIn <= {shiftIn[14:0], mdioIn};
  end

  assign changeSet = strb.done && baseValid && (baseTarget == frameTarget)
                     && (shiftIn != polledValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseValid   <= 1'b0;
      baseTarget  <= '0;
      polledValue <= '0;
    end else if (!pollOn) begin
      baseValid <= 1'b0;
    end else if (strb.done) begin
      baseValid   <= 1'b1;
      baseTarget  <= frameTarget;
      polledValue <= shiftIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) changeIrq <= 1'b0;
    else changeIrq <= (changeIrq && !irqClear) || changeSet;
  end

endmodule

// File: rtl/mgmt_autopoll.sv
module mgmt_autopoll
  import mgmt_autopoll_pkg::*;
#(
  parameter int MDC_DIV    = 8,
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  globalEn,
  input  logic                  cfgWrite,
  input  logic [15:0]           cfgData,
  output logic [15:0]           ctrlQ,
  input  logic [4:0]            dfltPhyAddr,
  input  logic                  dfltNoPre,
  input  logic [INTERVAL_W-1:0] intervalCycles,
  input  logic                  irqClear,
  output logic                  changeIrq,
  output logic [15:0]           polledValue,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  input  logic                  mdioIn
);

  seq_strobe_t strb;
  logic        pollOn;
  logic        skipPre;
  logic        frameDone;

  assign frameDone = strb.done;

  mgmt_autopoll_ctrl #(
    .MDC_DIV   (MDC_DIV),
    .INTERVAL_W(INTERVAL_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pollOn        (pollOn),
    .skipPre       (skipPre),
    .intervalCycles(intervalCycles),
    .mdc           (mdc),
    .strb          (strb)
  );

  mgmt_autopoll_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .globalEn   (globalEn),
    .cfgWrite   (cfgWrite),
    .cfgData    (cfgData),
    .dfltPhyAddr(dfltPhyAddr),
    .dfltNoPre  (dfltNoPre),
    .irqClear   (irqClear),
    .mdioIn     (mdioIn),
    .strb       (strb),
    .ctrlQ      (ctrlQ),
    .pollOn     (pollOn),
    .skipPre    (skipPre),
    .mdioOut    (mdioOut),
    .mdioOe     (mdioOe),
    .changeIrq  (changeIrq),
    .polledValue(polledValue)
  );

endmodule

// File: rtl/mgmt_autopoll_chk.sv
module mgmt_autopoll_chk (
  input logic        clk,
  input logic        rstN,
  input logic        globalEn,
  input logic [15:0] ctrlQ,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        changeIrq,
  input logic        irqClear,
  input logic        frameDone
);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[14:13] == 2'b00) && !ctrlQ[7]);

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn || !ctrlQ[15]) |=> (!mdc && !mdioOe));

  assert_mdio_steady_at_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> $stable(mdioOut));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (changeIrq && !irqClear) |=> changeIrq);

  assert_irq_at_frame_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changeIrq) |-> $past(frameDone));

endmodule

bind mgmt_autopoll mgmt_autopoll_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .globalEn (globalEn),
  .ctrlQ    (ctrlQ),
  .mdc      (mdc),
  .mdioOut  (mdioOut),
  .mdioOe   (mdioOe),
  .changeIrq(changeIrq),
  .irqClear (irqClear),
  .frameDone(frameDone)
);

// File: tb/sim_mgmt_autopoll.sv
module sim_mgmt_autopoll;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int HALF       = DIV / 2;
  localparam int IW         = 8;
  localparam int GAP        = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          globalEn = 1'b0;
  logic          cfgWrite = 1'b0;
  logic [15:0]   cfgData = '0;
  logic [15:0]   ctrlQ;
  logic [4:0]    dfltPhyAddr = '0;
  logic          dfltNoPre = 1'b0;
  logic [IW-1:0] intervalCycles = IW'(GAP);
  logic          irqClear = 1'b0;
  logic          changeIrq;
  logic [15:0]   polledValue;
  logic          mdc;
  logic          mdioOut;
  logic          mdioOe;
  logic          mdioIn = 1'b0;

  mgmt_autopoll #(.MDC_DIV(DIV), .INTERVAL_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .cfgWrite(cfgWrite),
    .cfgData(cfgData), .ctrlQ(ctrlQ), .dfltPhyAddr(dfltPhyAddr),
    .dfltNoPre(dfltNoPre), .intervalCycles(intervalCycles), .irqClear(irqClear),
    .changeIrq(changeIrq), .polledValue(polledValue), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- PHY model and frame decoder ----------------
  bit          monRun = 0;
  logic        mdcPrev = 1'b0;
  int          cyc = 0, lastRiseCyc = 0, riseCnt = 0;
  bit          haveRise = 0;
  int          monState = 0, ones = 0, hcnt = 0, k = 0;
  logic [12:0] hdr = '0;
  int          frameCnt = 0, lastPre = 0, crossGap = 0;
  logic [12:0] lastHdr = '0;
  int          taBad = 0, gapBad = 0, hdrBad = 0;
  logic [15:0] phyVal = '0, lastVal = '0;
  event        lastDataRise;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdcPrev) riseCnt++;
    if (!monRun) begin
      monState = 0; ones = 0; haveRise = 0;
    end else if (mdc && !mdcPrev) begin
      if (haveRise) begin
        if (monState == 0 && ones == 0) crossGap = cyc - lastRiseCyc;
        else if (cyc - lastRiseCyc != DIV) gapBad++;
      end
      haveRise = 1;
      lastRiseCyc = cyc;
      case (monState)
        0: if (mdioOe) begin
             if (mdioOut) ones++;
             else begin monState = 1; hcnt = 0; hdr = '0; end
           end
        1: begin
             if (!mdioOe) hdrBad++;
             hdr = {hdr[11:0], mdioOut};
             hcnt++;
             if (hcnt == 13) begin monState = 2; k = 0; end
           end
        default: begin
             k++;
             if (k <= 2 && mdioOe) taBad++;
             if (k == 18) begin
               lastPre = ones; lastHdr = hdr; lastVal = phyVal;
               frameCnt++; monState = 0; ones = 0;
               ->lastDataRise;
             end
           end
      endcase
    end else if (!mdc && mdcPrev) begin
      if (monState == 2 && k >= 2 && k <= 17) mdioIn = phyVal[15-(k-2)];
    end
    mdcPrev = mdc;
  end

  // ---------------- expected-value model ----------------
  logic [4:0] sAddr = '0, sReg = '0;
  bit         sNoPre = 0, sDflt = 0;
  bit         mValid = 0, mIrq = 0;
  logic [9:0] mTarget = '0;
  logic [15:0] mBase = '0;

  function automatic logic [15:0] cfgWord(input logic [4:0] a, input logic [4:0] r,
                                          input bit np, input bit d);
    return {1'b1, 2'b00, r, 1'b0, np, d, a};
  endfunction

  function automatic logic [4:0] expAddr();
    return sDflt ? dfltPhyAddr : sAddr;
  endfunction

  function automatic int expPre();
    return (sDflt ? dfltNoPre : sNoPre) ? 0 : 32;
  endfunction

  task automatic writeCfg(input logic [15:0] w);
    @(negedge clk); cfgWrite = 1'b1; cfgData = w;
    @(negedge clk); cfgWrite = 1'b0;
  endtask

  task automatic setCfg(input logic [4:0] a, input logic [4:0] r, input bit np, input bit d);
    sAddr = a; sReg = r; sNoPre = np; sDflt = d;
    writeCfg(cfgWord(a, r, np, d));
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
    mIrq = 0;
    check(changeIrq == 1'b0, "R8", "flag after clear", changeIrq, 0);
  endtask

  task automatic pulseAtDone();
    @(lastDataRise);
    repeat (HALF - 1) @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
  endtask

  task automatic pollStep(input string req, input bit clrAtDone);
    int n;
    logic [9:0] tgt;
    n = frameCnt;
    while (frameCnt == n) @(negedge clk);
    repeat (DIV) @(negedge clk);
    tgt = {expAddr(), sReg};
    check(lastPre == expPre(), "R4", {req, " preamble length"}, lastPre, expPre());
    check(lastHdr[12:10] == 3'b110, "R3", "start/opcode bits", lastHdr[12:10], 3'b110);
    check(lastHdr[9:5] == expAddr(), "R5", {req, " phy address"}, lastHdr[9:5], expAddr());
    check(lastHdr[4:0] == sReg, "R3", "register number", lastHdr[4:0], sReg);
    check(polledValue == lastVal, "R3", "captured value", polledValue, lastVal);
    if (clrAtDone) mIrq = 0;
    if (mValid && mTarget == tgt && mBase != lastVal) mIrq = 1;
    mValid = 1; mTarget = tgt; mBase = lastVal;
    check(changeIrq == mIrq, req, "change flag", changeIrq, mIrq);
  endtask

  task automatic clrStep(input string req);
    fork
      pulseAtDone();
      pollStep(req, 1'b1);
    join
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int r0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(ctrlQ == 16'h0, "R1", "control after reset", ctrlQ, 0);
    check(changeIrq == 1'b0 && mdc == 1'b0 && mdioOe == 1'b0, "R1", "outputs in reset",
          {changeIrq, mdc, mdioOe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reserved bits; R2: no activity without the global enable
    writeCfg(16'hFFFF);
    check(ctrlQ == 16'h9F7F, "R1", "reserved bits read zero", ctrlQ, 16'h9F7F);
    r0 = riseCnt;
    repeat (60) @(negedge clk);
    check(riseCnt == r0 && !mdioOe, "R2", "no MDC with globalEn low", riseCnt - r0, 0);
    writeCfg(16'h0000);

    // R2 other half: global enable alone is not enough
    globalEn = 1'b1;
    r0 = riseCnt;
    repeat (60) @(negedge clk);
    check(riseCnt == r0, "R2", "no MDC with enable bit low", riseCnt - r0, 0);

    // First poll: baseline only (R7)
    phyVal = 16'h1234;
    monRun = 1;
    setCfg(5'h0A, 5'h01, 0, 0);
    pollStep("R7", 0);
    phyVal = 16'h1234;
    pollStep("R6", 0);
    check(crossGap == DIV + GAP + 1, "R10", "gap across frames", crossGap, DIV + GAP + 1);
    check(taBad == 0, "R3", "MDIO released in turnaround", taBad, 0);
    check(gapBad == 0, "R9", "MDC period inside frame", gapBad, 0);
    phyVal = 16'h1235;
    pollStep("R6", 0);
    pollStep("R8", 0);
    clearIrq();

    // Clear in the comparison cycle, with and without a change (R8)
    phyVal = 16'hABCD;
    pollStep("R6", 0);
    phyVal = 16'h0F0F;
    clrStep("R8");
    check(changeIrq == 1'b1, "R8", "change beats clear", changeIrq, 1);
    clrStep("R8");
    check(changeIrq == 1'b0, "R8", "clear at frame end", changeIrq, 0);

    // Preamble suppression in explicit mode (R4)
    setCfg(5'h0A, 5'h01, 1, 0);
    pollStep("R4", 0);

    // Target change reloads baseline only (R7)
    phyVal = 16'h5555;
    setCfg(5'h0A, 5'h11, 1, 0);
    pollStep("R7", 0);

    // Default PHY mode (R5)
    dfltPhyAddr = 5'h1C; dfltNoPre = 1'b0;
    setCfg(5'h03, 5'h11, 1, 1);
    pollStep("R5", 0);
    dfltNoPre = 1'b1;
    pollStep("R5", 0);
    phyVal = 16'h5556;
    pollStep("R6", 0);
    clearIrq();

    // Disable, change value, re-enable: baseline only (R7)
    @(negedge clk); globalEn = 1'b0; monRun = 0; mValid = 0;
    r0 = riseCnt;
    repeat (80) @(negedge clk);
    check(riseCnt == r0, "R2", "idle while disabled", riseCnt - r0, 0);
    phyVal = 16'hFACE;
    globalEn = 1'b1; monRun = 1;
    pollStep("R7", 0);

    // Abort in the middle of a frame (R11)
    while (monState != 1) @(negedge clk);
    globalEn = 1'b0; monRun = 0; mValid = 0;
    @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R11", "abandoned frame", {mdc, mdioOe}, 0);
    repeat (20) @(negedge clk);
    globalEn = 1'b1; monRun = 1;
    pollStep("R7", 0);

    // Constrained random phase
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 3 != 0) phyVal = 16'($urandom);
      if ($urandom % 4 == 0) begin
        dfltPhyAddr = 5'($urandom);
        dfltNoPre = 1'($urandom);
        setCfg(5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
      end
      if ($urandom % 4 == 0) clearIrq();
      pollStep("R6", 0);
    end
    check(gapBad == 0, "R9", "MDC period over run", gapBad, 0);
    check(taBad == 0 && hdrBad == 0, "R3", "header drive and turnaround", taBad + hdrBad, 0);

    finishRun();
  end

endmodule